// File: doc/BRIEF.md
# Memory Copy Block Splitter

This block accepts a single copy job and breaks it into a chain of block descriptors for a linked-list DMA engine. The job is a source address, a destination address and a byte count. For every chunk it picks one transfer width for both sides. The width is the largest power of two, up to a configured ceiling, that divides both current addresses and the bytes still to move. It then counts the beats at that width, caps the count at the channel's maximum block size, and presents the descriptor fields on a valid/ready stream.

After each accepted descriptor, both addresses advance by the chunk and the remaining count shrinks by the same amount. The final descriptor of a job carries a last flag, and a one-cycle done pulse follows its acceptance. The per-channel beat cap and an optional burst-length limit are sampled when the job is accepted, and they stay fixed for the whole job. Writing descriptors to memory and linking them is left to the surrounding logic.

Top module: `mcpy_split`

## Requirements
- R1: The width exponent on `desc_width` is the index of the lowest set bit of (current source OR current destination OR remaining bytes OR 2^MAX_WEXP). It therefore lies between 0 and MAX_WEXP (default 6, i.e. 64-byte beats). The same width applies to both sides.
- R2: The beat count is the remaining bytes shifted right by the width exponent. If that exceeds the beat cap sampled at acceptance, the count becomes the cap and the chunk is the cap shifted left by the width exponent. Otherwise the chunk is all remaining bytes.
- R3: `desc_bts` carries the beat count minus one.
- R4: Every descriptor has `desc_lli_valid` = 1. `desc_last` = 1 only on the descriptor whose chunk equals the remaining bytes.
- R5: `desc_msize` is the fixed code 3'b001, which means bursts of 4 items. `desc_src_inc` and `desc_dst_inc` are 1, which means incrementing addresses.
- R6: When the burst limit is enabled at acceptance, `desc_rlen_en` and `desc_wlen_en` are 1 and `desc_rlen` and `desc_wlen` hold the configured length minus one. When it is disabled, all four are 0.
- R7: After a descriptor is accepted, the source and destination addresses each grow by the chunk and the remaining bytes fall by the chunk. The job yields exactly the number of descriptors that this stepping implies.
- R8: A job with zero length produces no descriptor. `done` goes high in the cycle after acceptance.
- R9: While `desc_valid` is 1 and `desc_ready` is 0, every descriptor field holds its value into the next cycle.
- R10: `done` is high for exactly one cycle, the cycle after the last descriptor is accepted. `req_ready` is 1 exactly when no job is in progress, which includes that done cycle.
- R11: After reset, `desc_valid` = 0, `req_ready` = 1 and `done` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Copy job offered |
| req_ready | output | 1 | Block idle, job accepted this cycle if offered |
| req_src | input | ADDR_W | Source byte address |
| req_dst | input | ADDR_W | Destination byte address |
| req_len | input | LEN_W | Byte count |
| cfg_max_beats | input | MAXB_W | Beat cap per descriptor (must be at least 1) |
| cfg_burst_en | input | 1 | Enable the burst-length limit |
| cfg_burst_len | input | BURST_W+1 | Burst-length limit, 1 to 2^BURST_W |
| desc_valid | output | 1 | Descriptor presented |
| desc_ready | input | 1 | Descriptor taken |
| desc_src | output | ADDR_W | Chunk source address |
| desc_dst | output | ADDR_W | Chunk destination address |
| desc_bts | output | MAXB_W | Beats minus one |
| desc_width | output | WEXP_W | Width exponent, both sides |
| desc_msize | output | 3 | Burst item code, fixed 3'b001 |
| desc_src_inc | output | 1 | Source increments |
| desc_dst_inc | output | 1 | Destination increments |
| desc_lli_valid | output | 1 | Descriptor valid bit |
| desc_last | output | 1 | Final descriptor of the job |
| desc_rlen_en | output | 1 | Read burst-length limit enable |
| desc_rlen | output | BURST_W | Read burst length minus one |
| desc_wlen_en | output | 1 | Write burst-length limit enable |
| desc_wlen | output | BURST_W | Write burst length minus one |
| done | output | 1 | One-cycle pulse at job end |

## Verification
Two events can land in the same cycle: the done pulse for the finished job and the acceptance of the next job, because `req_ready` returns high together with `done`. The bench provokes this by offering a second job in exactly the done cycle. It then checks that `done` drops at the next sample and that the new job's first descriptor carries its own width and beat count. Throttled `desc_ready` patterns also make descriptor stalls coincide with width changes and beat-cap truncation, and the bench checks that the held fields stay constant.

// File: rtl/mcpy_split_pkg.sv
package mcpy_split_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } split_state_e;

  // burst item code meaning four items per burst
  localparam logic [2:0] MSIZE_FOUR = 3'b001;

endpackage

// File: rtl/mcpy_width_sel.sv
module mcpy_width_sel #(
  parameter int ADDR_W   = 32,
  parameter int LEN_W    = 24,
  parameter int MAX_WEXP = 6,
  localparam int WEXP_W  = $clog2(MAX_WEXP + 1)
) (
  input  logic [ADDR_W-1:0] src,
  input  logic [ADDR_W-1:0] dst,
  input  logic [LEN_W-1:0]  rem,
  output logic [WEXP_W-1:0] wexp
);

  logic [MAX_WEXP-1:0] low_bits;

  assign low_bits = src[MAX_WEXP-1:0] | dst[MAX_WEXP-1:0] | rem[MAX_WEXP-1:0];

  // scan downward so the lowest set bit wins; ceiling when none is set
  always_comb begin
    wexp = WEXP_W'(MAX_WEXP);
    for (int i = MAX_WEXP - 1; i >= 0; i--) begin
      if (low_bits[i]) wexp = WEXP_W'(i);
    end
  end

endmodule

// File: rtl/mcpy_beat_cap.sv
module mcpy_beat_cap #(
  parameter int LEN_W  = 24,
  parameter int MAXB_W = 22,
  parameter int WEXP_W = 3
) (
  input  logic [LEN_W-1:0]  rem,
  input  logic [WEXP_W-1:0] wexp,
  input  logic [MAXB_W-1:0] max_beats,
  output logic [LEN_W-1:0]  beats,
  output logic [LEN_W-1:0]  chunk
);

  logic [LEN_W-1:0] full_beats;
  logic [LEN_W-1:0] cap_beats;

  assign full_beats = rem >> wexp;
  assign cap_beats  = LEN_W'(max_beats);

  always_comb begin
    if (full_beats > cap_beats) begin
      beats = cap_beats;
      chunk = cap_beats << wexp;
    end else begin
      beats = full_beats;
      chunk = rem;
    end
  end

endmodule

// File: rtl/mcpy_split.sv
module mcpy_split
  import mcpy_split_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LEN_W    = 24,
  parameter int MAXB_W   = 22,
  parameter int MAX_WEXP = 6,
  parameter int BURST_W  = 8,
  localparam int WEXP_W  = $clog2(MAX_WEXP + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_src,
  input  logic [ADDR_W-1:0]  req_dst,
  input  logic [LEN_W-1:0]   req_len,
  input  logic [MAXB_W-1:0]  cfg_max_beats,
  input  logic               cfg_burst_en,
  input  logic [BURST_W:0]   cfg_burst_len,
  output logic               desc_valid,
  input  logic               desc_ready,
  output logic [ADDR_W-1:0]  desc_src,
  output logic [ADDR_W-1:0]  desc_dst,
  output logic [MAXB_W-1:0]  desc_bts,
  output logic [WEXP_W-1:0]  desc_width,
  output logic [2:0]         desc_msize,
  output logic               desc_src_inc,
  output logic               desc_dst_inc,
  output logic               desc_lli_valid,
  output logic               desc_last,
  output logic               desc_rlen_en,
  output logic [BURST_W-1:0] desc_rlen,
  output logic               desc_wlen_en,
  output logic [BURST_W-1:0] desc_wlen,
  output logic               done
);

  split_state_e       state_q, state_d;
  logic [ADDR_W-1:0]  src_q, src_d;
  logic [ADDR_W-1:0]  dst_q, dst_d;
  logic [LEN_W-1:0]   rem_q, rem_d;
  logic [MAXB_W-1:0]  maxb_q;
  logic               ben_q;
  logic [BURST_W-1:0] blen_m1_q;
  logic               done_q, done_d;

  logic               req_fire, desc_fire, cfg_load;
  logic [WEXP_W-1:0]  wexp;
  logic [LEN_W-1:0]   beats, chunk_len;
  logic               is_last;

  assign req_ready = (state_q == ST_IDLE);
  assign req_fire  = req_valid && req_ready;
  assign desc_fire = desc_valid && desc_ready;
  assign cfg_load  = req_fire && (req_len != '0);

  mcpy_width_sel #(
    .ADDR_W  (ADDR_W),
    .LEN_W   (LEN_W),
    .MAX_WEXP(MAX_WEXP)
  ) u_width (
    .src (src_q),
    .dst (dst_q),
    .rem (rem_q),
    .wexp(wexp)
  );

  mcpy_beat_cap #(
    .LEN_W (LEN_W),
    .MAXB_W(MAXB_W),
    .WEXP_W(WEXP_W)
  ) u_cap (
    .rem      (rem_q),
    .wexp     (wexp),
    .max_beats(maxb_q),
    .beats    (beats),
    .chunk    (chunk_len)
  );

  assign is_last = (chunk_len == rem_q);

  // next-state
  always_comb begin
    state_d = state_q;
    src_d   = src_q;
    dst_d   = dst_q;
    rem_d   = rem_q;
    done_d  = 1'b0;
    if (req_fire) begin
      src_d = req_src;
      dst_d = req_dst;
      rem_d = req_len;
      if (req_len == '0) done_d = 1'b1;
      else               state_d = ST_RUN;
    end else if (desc_fire) begin
      src_d = src_q + ADDR_W'(chunk_len);
      dst_d = dst_q + ADDR_W'(chunk_len);
      rem_d = rem_q - chunk_len;
      if (is_last) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      rem_q <= '0;
    end else if (req_fire || desc_fire) begin
      src_q <= src_d;
      dst_q <= dst_d;
      rem_q <= rem_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      maxb_q    <= '0;
      ben_q     <= 1'b0;
      blen_m1_q <= '0;
    end else if (cfg_load) begin
      maxb_q    <= cfg_max_beats;
      ben_q     <= cfg_burst_en;
      blen_m1_q <= cfg_burst_en ? BURST_W'(cfg_burst_len - 1'b1) : '0;
    end
  end

  // descriptor fields
  assign desc_valid     = (state_q == ST_RUN);
  assign desc_src       = src_q;
  assign desc_dst       = dst_q;
  assign desc_bts       = MAXB_W'(beats - 1'b1);
  assign desc_width     = wexp;
  assign desc_msize     = MSIZE_FOUR;
  assign desc_src_inc   = 1'b1;
  assign desc_dst_inc   = 1'b1;
  assign desc_lli_valid = 1'b1;
  assign desc_last      = is_last;
  assign desc_rlen_en   = ben_q;
  assign desc_rlen      = blen_m1_q;
  assign desc_wlen_en   = ben_q;
  assign desc_wlen      = blen_m1_q;
  assign done           = done_q;

  // assertions
  a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && !desc_ready) |=> (desc_valid && $stable(desc_src) && $stable(desc_dst)
                                     && $stable(desc_bts) && $stable(desc_width) && $stable(desc_last)));

  a_r7_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_fire && !desc_last) |=> (desc_valid && desc_src == $past(desc_src) + $past(ADDR_W'(chunk_len))
                                   && desc_dst == $past(desc_dst) + $past(ADDR_W'(chunk_len))));

  a_r10_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_fire && desc_last) |=> (done && req_ready && !desc_valid));

  a_r8_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && req_len == '0) |=> (done && !desc_valid));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done || $past(req_fire));

  a_r1_width_bound: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> (desc_width <= WEXP_W'(MAX_WEXP)));

endmodule

// File: tb/mcpy_split_tb.sv
`timescale 1ns/1ps
module mcpy_split_tb;

  localparam int NV = 8;

  logic        clk, rst_n;
  logic        req_valid, req_ready;
  logic [31:0] req_src, req_dst;
  logic [23:0] req_len;
  logic [21:0] cfg_max_beats;
  logic        cfg_burst_en;
  logic [8:0]  cfg_burst_len;
  logic        desc_valid, desc_ready;
  logic [31:0] desc_src, desc_dst;
  logic [21:0] desc_bts;
  logic [2:0]  desc_width, desc_msize;
  logic        desc_src_inc, desc_dst_inc, desc_lli_valid, desc_last;
  logic        desc_rlen_en, desc_wlen_en;
  logic [7:0]  desc_rlen, desc_wlen;
  logic        done;

  int checks = 0;
  int errors = 0;

  // src, dst, len, max beats, burst enable, burst len, descriptor count, throttle
  localparam logic [31:0] V_SRC [NV] = '{32'h1000, 32'h1001, 32'h1000, 32'h0,
                                         32'h100, 32'h0, 32'h4, 32'h0};
  localparam logic [31:0] V_DST [NV] = '{32'h2000, 32'h2000, 32'h2004, 32'h0,
                                         32'h200, 32'h0, 32'h4, 32'h0};
  localparam logic [23:0] V_LEN [NV] = '{24'h100, 24'd10, 24'h40, 24'd6,
                                         24'h1000, 24'd0, 24'h44, 24'd1};
  localparam logic [21:0] V_MAXB [NV] = '{22'd64, 22'd64, 22'd4, 22'd64,
                                          22'd8, 22'd64, 22'd1, 22'd1};
  localparam logic        V_BEN [NV] = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};
  localparam logic [8:0]  V_BLEN [NV] = '{9'd16, 9'd1, 9'd1, 9'd1, 9'd256, 9'd1, 9'd1, 9'd1};
  localparam int          V_NDESC [NV] = '{1, 1, 4, 1, 8, 0, 9, 1};
  localparam logic        V_THR [NV] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};

  mcpy_split u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_src(req_src), .req_dst(req_dst), .req_len(req_len),
    .cfg_max_beats(cfg_max_beats), .cfg_burst_en(cfg_burst_en), .cfg_burst_len(cfg_burst_len),
    .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_src(desc_src), .desc_dst(desc_dst), .desc_bts(desc_bts), .desc_width(desc_width),
    .desc_msize(desc_msize), .desc_src_inc(desc_src_inc), .desc_dst_inc(desc_dst_inc),
    .desc_lli_valid(desc_lli_valid), .desc_last(desc_last),
    .desc_rlen_en(desc_rlen_en), .desc_rlen(desc_rlen),
    .desc_wlen_en(desc_wlen_en), .desc_wlen(desc_wlen),
    .done(done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int exp_width(input logic [31:0] s, input logic [31:0] d, input logic [23:0] r);
    logic [31:0] m;
    m = s | d | {8'h0, r} | 32'h40;
    for (int i = 0; i < 7; i++) if (m[i]) return i;
    return 6;
  endfunction

  task automatic send_req(input logic [31:0] s, input logic [31:0] d, input logic [23:0] l,
                          input logic [21:0] mb, input logic be, input logic [8:0] bl);
    req_src = s; req_dst = d; req_len = l;
    cfg_max_beats = mb; cfg_burst_en = be; cfg_burst_len = bl;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    req_src = 32'hdead_beef; cfg_max_beats = 22'd3; cfg_burst_en = ~be;
  endtask

  task automatic run_job(input int k);
    logic [31:0] cs, cd;
    logic [23:0] rem;
    int cnt, guard, w;
    longint beats, chunk;
    bit held;
    logic [31:0] h_src, h_dst;
    logic [21:0] h_bts;
    logic [2:0]  h_w;
    logic        h_last, r;
    cs = V_SRC[k]; cd = V_DST[k]; rem = V_LEN[k];
    cnt = 0; guard = 0; held = 0;
    send_req(V_SRC[k], V_DST[k], V_LEN[k], V_MAXB[k], V_BEN[k], V_BLEN[k]);
    if (V_LEN[k] == 0) begin
      chk(done === 1'b1 && desc_valid === 1'b0, "R8 zero length", {done, desc_valid}, 2'b10);
      @(negedge clk);
      chk(done === 1'b0, "R10 pulse width", done, 0);
      return;
    end
    while (rem != 0 && guard < 400) begin
      if (held) begin
        chk(desc_src === h_src && desc_dst === h_dst && desc_bts === h_bts
            && desc_width === h_w && desc_last === h_last, "R9 stall hold", desc_src, h_src);
        held = 0;
      end
      r = V_THR[k] ? (guard % 3 != 0) : 1'b1;
      desc_ready = r;
      chk(desc_valid === 1'b1, "R4 valid during job", desc_valid, 1);
      chk(done === 1'b0 && req_ready === 1'b0, "R10 busy", {done, req_ready}, 0);
      if (desc_valid && r) begin
        w = exp_width(cs, cd, rem);
        beats = longint'(rem) >> w;
        if (beats > longint'(V_MAXB[k])) begin
          beats = V_MAXB[k]; chunk = beats << w;
        end else chunk = rem;
        chk(desc_width === 3'(w), "R1 width", desc_width, w);
        chk(desc_bts === 22'(beats - 1), "R2 R3 beats", desc_bts, beats - 1);
        chk(desc_src === cs && desc_dst === cd, "R7 addresses", desc_src, cs);
        chk(desc_last === (longint'(rem) == chunk) && desc_lli_valid === 1'b1, "R4 flags",
            {desc_lli_valid, desc_last}, {1'b1, longint'(rem) == chunk});
        chk(desc_msize === 3'b001 && desc_src_inc === 1'b1 && desc_dst_inc === 1'b1, "R5 fixed",
            {desc_msize, desc_src_inc, desc_dst_inc}, 5'b00111);
        chk(desc_rlen_en === V_BEN[k] && desc_wlen_en === V_BEN[k]
            && desc_rlen === (V_BEN[k] ? 8'(V_BLEN[k] - 1) : 8'h0)
            && desc_wlen === desc_rlen, "R6 burst limit", desc_rlen,
            V_BEN[k] ? V_BLEN[k] - 1 : 0);
        cs = cs + 32'(chunk); cd = cd + 32'(chunk); rem = rem - 24'(chunk);
        cnt++;
      end else if (desc_valid) begin
        held = 1; h_src = desc_src; h_dst = desc_dst; h_bts = desc_bts;
        h_w = desc_width; h_last = desc_last;
      end
      @(negedge clk);
      guard++;
    end
    desc_ready = 1'b0;
    chk(cnt == V_NDESC[k], "R7 descriptor count", cnt, V_NDESC[k]);
    chk(done === 1'b1 && req_ready === 1'b1 && desc_valid === 1'b0, "R10 done after last",
        {done, req_ready, desc_valid}, 3'b110);
    @(negedge clk);
    chk(done === 1'b0, "R10 pulse width", done, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; desc_ready = 1'b0;
    req_src = '0; req_dst = '0; req_len = '0;
    cfg_max_beats = 22'd1; cfg_burst_en = 1'b0; cfg_burst_len = 9'd1;
    repeat (3) @(negedge clk);
    chk(desc_valid === 1'b0 && req_ready === 1'b1 && done === 1'b0, "R11 reset state",
        {desc_valid, req_ready, done}, 3'b010);
    rst_n = 1'b1;
    @(negedge clk);
    chk(desc_valid === 1'b0 && req_ready === 1'b1 && done === 1'b0, "R11 after release",
        {desc_valid, req_ready, done}, 3'b010);

    for (int k = 0; k < NV; k++) run_job(k);

    // R10: new job offered in the done cycle of the previous one
    send_req(32'h0, 32'h0, 24'd8, 22'd64, 1'b0, 9'd1);
    chk(desc_valid === 1'b1 && desc_width === 3'd3 && desc_last === 1'b1, "R1 job A",
        desc_width, 3);
    desc_ready = 1'b1;
    @(negedge clk);
    desc_ready = 1'b0;
    chk(done === 1'b1 && req_ready === 1'b1, "R10 done with ready", {done, req_ready}, 2'b11);
    send_req(32'h10, 32'h20, 24'd4, 22'd64, 1'b0, 9'd1);
    chk(done === 1'b0 && desc_valid === 1'b1, "R10 back to back", {done, desc_valid}, 2'b01);
    chk(desc_width === 3'd2 && desc_bts === 22'd0 && desc_src === 32'h10, "R2 job B",
        desc_width, 2);
    // R9: long stall leaves the descriptor unchanged
    repeat (5) @(negedge clk);
    chk(desc_valid === 1'b1 && desc_src === 32'h10 && desc_dst === 32'h20, "R9 long stall",
        desc_src, 32'h10);
    desc_ready = 1'b1;
    @(negedge clk);
    desc_ready = 1'b0;
    chk(done === 1'b1 && desc_valid === 1'b0, "R10 job B end", {done, desc_valid}, 2'b10);
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule